// File: doc/BRIEF.md
# Segment Bounds and Rights Checker

This block screens one memory access against the segment it is made through. It runs while protection is on and the core is outside 64-bit mode. It reports a single general-protection fault and the segment-relative offset of the access. The segment descriptor is already loaded, and the pipeline presents these fields on the block's inputs:

- the selector state,
- the access rights,
- the base and the limit.

The access side presents:

- the linear address,
- the byte count,
- the kind of access,
- a store-probe flag.

The block is purely combinational. It sits in the address-generation path ahead of paging.

The offset is 16 or 32 bits wide. The code segment's default-size bit and the address-size override together pick the width. The block checks the first byte and the last byte of the access against the limit. For segments that grow downward, the limit test is inverted.

Top module: `seg_guard`

## Requirements
- R1: When `chk_en` is 0 or `long_mode` is 1, `gp_fault` is 0 for every other input value.
- R2: A null selector (`sel_null`=1) raises `gp_fault` unless `sel_exempt`=1.
- R3: On a data segment (`is_data`=1) with `seg_wr`=0, either of the following raises `gp_fault`:
  - a write (`acc_kind`=2'b01),
  - any access with `store_chk`=1.
- R4: On a data segment with `seg_rd`=0, a read (`acc_kind`=2'b00) raises `gp_fault`. An execute (`acc_kind`=2'b10, and also 2'b11) does not raise it.
- R5: When `is_data`=0, the block ignores the following inputs:
  - `seg_rd`, `seg_wr` and `store_chk`,
  - `seg_expdn`; the segment is limit-checked as a normal, upward segment.
- R6: The offset width is chosen as follows:
  - 16 bits when `cs_dflt32` equals `asz_ovr`, otherwise 32 bits;
  - `offset` is (`lin_addr` − `seg_base`) cut to that width, with the upper bits 0;
  - `offset` is driven even when the checks are bypassed.
- R7: On a normal segment, `gp_fault` is raised in either of two cases:
  - `offset` exceeds `seg_limit`;
  - the last byte (`offset` + `acc_size` − 1) exceeds `seg_limit`.
- R8: On an expand-down data segment (`seg_expdn`=1), `gp_fault` is raised in either of two cases:
  - `offset` is less than or equal to `seg_limit`;
  - the last byte is less than or equal to `seg_limit`.
- R9: `acc_size` is taken as 1 to 8 bytes. The last-byte sum is formed with one extra bit, so any access whose last byte carries past the selected offset width raises `gp_fault`. This holds for both normal and expand-down segments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| chk_en | input | 1 | Protection enabled |
| long_mode | input | 1 | Core in 64-bit mode; the checks are bypassed |
| sel_null | input | 1 | Segment selector is null |
| sel_exempt | input | 1 | Segment is exempt from the null-selector check |
| is_data | input | 1 | Segment is a data or stack segment, so its rights bits apply |
| seg_rd | input | 1 | Segment is readable |
| seg_wr | input | 1 | Segment is writable |
| seg_expdn | input | 1 | Segment grows downward |
| seg_base | input | 32 | Segment base |
| seg_limit | input | 32 | Segment limit |
| cs_dflt32 | input | 1 | Code segment default size is 32-bit |
| asz_ovr | input | 1 | Address-size override present |
| lin_addr | input | 32 | Address of the access |
| acc_size | input | 4 | Bytes accessed, 1 to 8 |
| acc_kind | input | 2 | 00 read, 01 write, 10 or 11 execute |
| store_chk | input | 1 | Probe the access as if it were a store |
| gp_fault | output | 1 | General-protection fault, error code zero |
| offset | output | 32 | Segment-relative offset of the first byte |

## Verification
Both results, `gp_fault` and `offset`, are functions of the present inputs with no register between them. Each result is therefore due in the same cycle as its stimulus, once the combinational logic settles. The bench changes all inputs at once in a scenario task. It waits a fixed 2 ns before reading the outputs, and it applies no new stimulus until that read is done. The clock in the bench only paces the watchdog, and the checks never sample on one of its edges.

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int SIZE_W   = 4
) (
  input  logic              chk_en,
  input  logic              long_mode,
  input  logic              sel_null,
  input  logic              sel_exempt,
  input  logic              is_data,
  input  logic              seg_rd,
  input  logic              seg_wr,
  input  logic              seg_expdn,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              cs_dflt32,
  input  logic              asz_ovr,
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [1:0]        acc_kind,
  input  logic              store_chk,
  output logic              gp_fault,
  output logic [ADDR_W-1:0] offset
);

  localparam int SUM_W = ADDR_W + 1;

  logic              active, narrow, expdn_eff;
  logic [ADDR_W-1:0] diff, end_off;
  logic [SUM_W-1:0]  last_sum;
  logic              wraps, null_bad, rights_bad, bound_bad;

  assign active    = chk_en & ~long_mode;
  assign narrow    = (cs_dflt32 == asz_ovr);
  assign expdn_eff = is_data & seg_expdn;

  assign diff   = lin_addr - seg_base;
  assign offset = narrow ? {{(ADDR_W-NARROW_W){1'b0}}, diff[NARROW_W-1:0]} : diff;

  assign last_sum = {1'b0, offset} + {{(SUM_W-SIZE_W){1'b0}}, acc_size} - SUM_W'(1);
  assign wraps    = narrow ? last_sum[NARROW_W] : last_sum[ADDR_W];
  assign end_off  = narrow ? {{(ADDR_W-NARROW_W){1'b0}}, last_sum[NARROW_W-1:0]}
                           : last_sum[ADDR_W-1:0];

  assign null_bad   = sel_null & ~sel_exempt;
  assign rights_bad = is_data & ((~seg_wr & (acc_kind == 2'b01 | store_chk)) |
                                 (~seg_rd & (acc_kind == 2'b00)));

  always_comb begin
    if (expdn_eff)
      bound_bad = wraps | (offset <= seg_limit) | (end_off <= seg_limit);
    else
      bound_bad = wraps | (offset > seg_limit) | (end_off > seg_limit);
  end

  assign gp_fault = active & (null_bad | rights_bad | bound_bad);

  always_comb begin
    if (!$isunknown({chk_en, long_mode, sel_null, sel_exempt, is_data, seg_rd, seg_wr,
                     seg_expdn, seg_base, seg_limit, cs_dflt32, asz_ovr, lin_addr,
                     acc_size, acc_kind, store_chk})) begin
      assert_bypass_R1: assert (!((!chk_en || long_mode) && gp_fault));
      assert_null_R2: assert (!(chk_en && !long_mode && sel_null && !sel_exempt) || gp_fault);
      assert_write_R3: assert (!(chk_en && !long_mode && is_data && !seg_wr &&
                                 (acc_kind == 2'b01 || store_chk)) || gp_fault);
      assert_read_R4: assert (!(chk_en && !long_mode && is_data && !seg_rd &&
                                acc_kind == 2'b00) || gp_fault);
      assert_narrow_R6: assert (!(cs_dflt32 == asz_ovr) || offset < (ADDR_W'(1) << NARROW_W));
      assert_upper_R7: assert (!(chk_en && !long_mode && !(is_data && seg_expdn) &&
                                 offset > seg_limit) || gp_fault);
      assert_lower_R8: assert (!(chk_en && !long_mode && is_data && seg_expdn &&
                                 offset <= seg_limit) || gp_fault);
    end
  end

endmodule

// File: tb/seg_guard_test.sv
module seg_guard_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        chk_en, long_mode, sel_null, sel_exempt, is_data, seg_rd, seg_wr, seg_expdn;
  logic [31:0] seg_base, seg_limit, lin_addr, offset;
  logic        cs_dflt32, asz_ovr, store_chk, gp_fault;
  logic [3:0]  acc_size;
  logic [1:0]  acc_kind;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  seg_guard uut (
    .chk_en(chk_en), .long_mode(long_mode), .sel_null(sel_null), .sel_exempt(sel_exempt),
    .is_data(is_data), .seg_rd(seg_rd), .seg_wr(seg_wr), .seg_expdn(seg_expdn),
    .seg_base(seg_base), .seg_limit(seg_limit), .cs_dflt32(cs_dflt32), .asz_ovr(asz_ovr),
    .lin_addr(lin_addr), .acc_size(acc_size), .acc_kind(acc_kind), .store_chk(store_chk),
    .gp_fault(gp_fault), .offset(offset)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 20000)", cyc);
      summary();
      $finish;
    end
  end

  task automatic defaults();
    chk_en = 1; long_mode = 0; sel_null = 0; sel_exempt = 0;
    is_data = 1; seg_rd = 1; seg_wr = 1; seg_expdn = 0;
    seg_base = 32'h1000; seg_limit = 32'hFFFF;
    cs_dflt32 = 1; asz_ovr = 0;
    lin_addr = 32'h1010; acc_size = 4; acc_kind = 2'b00; store_chk = 0;
  endtask

  task automatic expect_fault(string req, bit exp);
    #2;
    total++;
    if (gp_fault !== exp) begin
      fails++;
      $display("FAIL %s: gp_fault actual %0b expected %0b", req, gp_fault, exp);
    end
    #8;
  endtask

  task automatic expect_off(string req, logic [31:0] exp);
    #2;
    total++;
    if (offset !== exp) begin
      fails++;
      $display("FAIL %s: offset actual %h expected %h", req, offset, exp);
    end
    #8;
  endtask

  task automatic t_baseline();
    defaults();
    expect_fault("R7 in-bounds baseline", 0);
    expect_off("R6 baseline offset", 32'h10);
  endtask

  task automatic t_bypass_R1();
    defaults(); seg_limit = 0; chk_en = 0;
    expect_fault("R1 protection off", 0);
    chk_en = 1; long_mode = 1;
    expect_fault("R1 long mode", 0);
    expect_off("R6 offset driven while bypassed", 32'h10);
    long_mode = 0;
    expect_fault("R1 checks active", 1);
  endtask

  task automatic t_null_R2();
    defaults(); sel_null = 1;
    expect_fault("R2 null selector", 1);
    sel_exempt = 1;
    expect_fault("R2 exempt null selector", 0);
  endtask

  task automatic t_write_R3();
    defaults(); seg_wr = 0; acc_kind = 2'b01;
    expect_fault("R3 write to read-only", 1);
    acc_kind = 2'b00; store_chk = 1;
    expect_fault("R3 store probe on read-only", 1);
    store_chk = 0;
    expect_fault("R3 plain read of read-only", 0);
  endtask

  task automatic t_read_R4();
    defaults(); seg_rd = 0;
    expect_fault("R4 read of execute-only", 1);
    acc_kind = 2'b10;
    expect_fault("R4 execute of non-readable", 0);
    acc_kind = 2'b11;
    expect_fault("R4 kind 11 as execute", 0);
  endtask

  task automatic t_nondata_R5();
    defaults(); is_data = 0; seg_wr = 0; seg_rd = 0; acc_kind = 2'b01; store_chk = 1;
    expect_fault("R5 rights ignored on non-data", 0);
    defaults(); is_data = 0; seg_expdn = 1;
    expect_fault("R5 expand-down ignored on non-data", 0);
  endtask

  task automatic t_width_R6();
    defaults(); cs_dflt32 = 1; asz_ovr = 1; lin_addr = 32'h0FF0;
    expect_off("R6 16-bit (both set)", 32'hFFF0);
    expect_fault("R6 16-bit in limit", 0);
    cs_dflt32 = 0; asz_ovr = 0;
    expect_off("R6 16-bit (both clear)", 32'hFFF0);
    cs_dflt32 = 0; asz_ovr = 1;
    expect_off("R6 32-bit via override", 32'hFFFFFFF0);
    expect_fault("R7 32-bit offset beyond limit", 1);
  endtask

  task automatic t_normal_R7();
    defaults(); seg_base = 0; seg_limit = 32'hFF; lin_addr = 32'hFC;
    expect_fault("R7 last byte at limit", 0);
    lin_addr = 32'hFD;
    expect_fault("R7 last byte past limit", 1);
    lin_addr = 32'h100;
    expect_fault("R7 first byte past limit", 1);
  endtask

  task automatic t_expdn_R8();
    defaults(); seg_base = 0; seg_limit = 32'h0FFF; seg_expdn = 1; lin_addr = 32'h1000;
    expect_fault("R8 just above limit", 0);
    lin_addr = 32'h0FFE;
    expect_fault("R8 straddles limit", 1);
    lin_addr = 32'h0FFF; acc_size = 1;
    expect_fault("R8 byte at limit", 1);
    lin_addr = 32'hFFFFFFFC; acc_size = 4;
    expect_fault("R8 top of space", 0);
  endtask

  task automatic t_wrap_R9();
    defaults(); seg_base = 0; seg_limit = 32'hFFFFFFFF; cs_dflt32 = 0; asz_ovr = 0;
    lin_addr = 32'hFFFE; acc_size = 2;
    expect_fault("R9 16-bit ends at top", 0);
    acc_size = 4;
    expect_fault("R9 16-bit wraps", 1);
    defaults(); seg_base = 0; seg_limit = 0; seg_expdn = 1; lin_addr = 32'hFFFFFFFE; acc_size = 4;
    expect_fault("R9 32-bit wrap expand-down", 1);
    acc_size = 8; lin_addr = 32'hFFFFFFF8;
    expect_fault("R9 8-byte access at top", 0);
  endtask

  initial begin
    defaults();
    #3;
    t_baseline();
    t_bypass_R1();
    t_null_R2();
    t_write_R3();
    t_read_R4();
    t_nondata_R5();
    t_width_R6();
    t_normal_R7();
    t_expdn_R8();
    t_wrap_R9();
    done = 1;
    summary();
    $finish;
  end

endmodule